// File: doc/BRIEF.md
# Correlating Two-Level Branch Direction Predictor

This block guesses whether a conditional branch will be taken, using both the branch's own address and the outcomes of the branches that ran just before it. A shift register keeps the directions of the most recent resolved branches. The low address bits of the branch pick a row of saturating counters, and the history bits pick one counter within that row. The most significant bit of that counter is the guess. The guess is returned in the same cycle as the fetch address.

When a branch resolves, the pipeline sends back the branch address, the real direction and the history value that came with the prediction. The block moves the chosen counter one step toward the real direction. It then builds the new global history from the returned history with the new outcome shifted in. Because the history comes from neighbouring branches, two branches whose outcomes depend on each other can be predicted correctly even when each one alone looks random.

Top module: `corr_bp`

## Requirements
- R1: While reset is high and on the cycle after it, the global history is all zeros. Every counter holds the weak not-taken value: MSB 0 and all other bits 1 (binary 01 when n=2, 0 when n=1). So `pred_taken` is 0 for every fetch address and `pred_hist` is 0.
- R2: `pred_taken` is the MSB of the counter at entry address {fetch_pc[PC_LSB+IDX_W-1:PC_LSB], history}, where the history forms the low bits. It depends combinationally on `fetch_pc` in the same cycle, and `pred_hist` shows the current history.
- R3: A resolve with outcome taken adds one to the addressed counter and a resolve with outcome not-taken subtracts one. The count holds at all-ones and at zero instead of wrapping.
- R4: With n=2, a counter at the strong value needs two consecutive opposite outcomes before its prediction changes.
- R5: Within one row, each history value selects its own counter. Training one history pattern leaves the others unchanged.
- R6: There is no tag check. Addresses whose index bits are equal share the same counters.
- R7: On a resolve, the history becomes {res_hist[m-2:0], res_taken}, with the newest outcome in bit 0.
- R8: The counter updated on a resolve is selected by `res_hist`, not by the current history.
- R9: While `res_valid` is low, no counter and no history bit changes, whatever the other resolve inputs carry.
- R10: When a fetch and a resolve address the same entry in one cycle, the prediction shows the value before the update.
- R11: With m=1 and n=1, two correlated branches that run in the alternating pattern taken,taken / not-taken,not-taken mispredict only during the first pass and never after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | input | PC_W | Address of the branch being fetched |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_hist | output | HIST_W | History used for this prediction; return it with the resolve |
| res_valid | input | 1 | Resolve request strobe |
| res_pc | input | PC_W | Address of the resolved branch |
| res_taken | input | 1 | Actual direction, 1 = taken |
| res_hist | input | HIST_W | History captured when the branch was predicted |

## Verification
The main instance uses a 16-bit address, three index bits above two ignored low bits, two history bits and two-bit counters. That gives only 32 entries, so every row and every history pattern is easy to reach. Address 0x20 aliases onto row 0, which lets the bench check sharing between addresses. A second instance uses one history bit and one-bit counters, so the bench can replay the correlated two-branch pattern and count its mispredictions per pass.

// File: rtl/corr_bp_pkg.sv
package corr_bp_pkg;
  localparam int CTR_MAX_W = 8;
  typedef logic [CTR_MAX_W-1:0] ctr_word_t;

  function automatic ctr_word_t ctr_full(input int unsigned w);
    return ctr_word_t'((1 << w) - 1);
  endfunction

  // MSB clear, every lower bit set: the weakest not-taken state
  function automatic ctr_word_t ctr_weak_nt(input int unsigned w);
    return ctr_word_t'((1 << (w - 1)) - 1);
  endfunction

  function automatic ctr_word_t ctr_step(input ctr_word_t v, input int unsigned w,
                                         input logic up);
    if (up) return (v == ctr_full(w)) ? v : v + ctr_word_t'(1);
    return (v == '0) ? v : v - ctr_word_t'(1);
  endfunction
endpackage

// File: rtl/corr_bp_hist.sv
module corr_bp_hist #(
  parameter int HIST_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_en,
  input  logic [HIST_W-1:0] upd_hist,
  input  logic              upd_taken,
  output logic [HIST_W-1:0] hist
);
  logic [HIST_W-1:0] hist_next;

  generate
    if (HIST_W == 1) begin : g_single
      logic unused_hist;
      assign unused_hist = upd_hist[0];
      assign hist_next   = upd_taken;
    end else begin : g_shift
      logic unused_hist;
      assign unused_hist = upd_hist[HIST_W-1];
      assign hist_next   = {upd_hist[HIST_W-2:0], upd_taken};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)         hist <= '0;
    else if (upd_en) hist <= hist_next;
  end

  assert_hist_clear_R1: assert property (@(posedge clk) rst |=> (hist == '0))
    else $error("history not cleared by reset");

  assert_hist_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !upd_en |=> $stable(hist))
    else $error("history moved without a resolve");

  assert_hist_newest_R7: assert property (@(posedge clk) disable iff (rst)
    upd_en |=> (hist[0] == $past(upd_taken)))
    else $error("newest outcome not in bit 0");
endmodule

// File: rtl/corr_bp_table.sv
module corr_bp_table
  import corr_bp_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CTR_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_taken,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_taken
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [CTR_W-1:0] CTR_INIT = CTR_W'(ctr_weak_nt(CTR_W));

  logic [CTR_W-1:0] ctr_mem [DEPTH];
  logic [CTR_W-1:0] wr_old;
  logic [CTR_W-1:0] wr_new;
  ctr_word_t        step_word;

  assign wr_old    = ctr_mem[wr_addr];
  assign step_word = ctr_step(ctr_word_t'(wr_old), CTR_W, wr_taken);
  assign wr_new    = step_word[CTR_W-1:0];
  assign rd_taken  = ctr_mem[rd_addr][CTR_W-1];

  generate
    if (CTR_W < CTR_MAX_W) begin : g_unused_hi
      logic unused_step;
      assign unused_step = ^step_word[CTR_MAX_W-1:CTR_W];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) ctr_mem[i] <= CTR_INIT;
    end else if (wr_en) begin
      ctr_mem[wr_addr] <= wr_new;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst && wr_en) begin
      assert_sat_dir_R3: assert (wr_taken ? (wr_new >= wr_old) : (wr_new <= wr_old))
        else $error("counter stepped the wrong way or wrapped");
    end
  end
endmodule

// File: rtl/corr_bp.sv
module corr_bp #(
  parameter int PC_W   = 32,
  parameter int PC_LSB = 2,
  parameter int IDX_W  = 6,
  parameter int HIST_W = 2,
  parameter int CTR_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PC_W-1:0]   fetch_pc,
  output logic              pred_taken,
  output logic [HIST_W-1:0] pred_hist,
  input  logic              res_valid,
  input  logic [PC_W-1:0]   res_pc,
  input  logic              res_taken,
  input  logic [HIST_W-1:0] res_hist
);
  localparam int ADDR_W = IDX_W + HIST_W;

  logic [HIST_W-1:0] ghist;
  logic [ADDR_W-1:0] rd_addr;
  logic [ADDR_W-1:0] wr_addr;
  logic              unused_pc;

  assign unused_pc = ^fetch_pc ^ ^res_pc;
  assign rd_addr   = {fetch_pc[PC_LSB +: IDX_W], ghist};
  assign wr_addr   = {res_pc[PC_LSB +: IDX_W], res_hist};
  assign pred_hist = ghist;

  corr_bp_hist #(.HIST_W(HIST_W)) u_hist (
    .clk       (clk),
    .rst       (rst),
    .upd_en    (res_valid),
    .upd_hist  (res_hist),
    .upd_taken (res_taken),
    .hist      (ghist)
  );

  corr_bp_table #(.ADDR_W(ADDR_W), .CTR_W(CTR_W)) u_table (
    .clk      (clk),
    .rst      (rst),
    .rd_addr  (rd_addr),
    .rd_taken (pred_taken),
    .wr_en    (res_valid),
    .wr_addr  (wr_addr),
    .wr_taken (res_taken)
  );

  assert_reset_pred_R1: assert property (@(posedge clk) rst |=> !pred_taken)
    else $error("prediction taken right after reset");
endmodule

// File: tb/corr_bp_tb.sv
module corr_bp_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] fetch_pc = '0;
  logic        pred_taken;
  logic [1:0]  pred_hist;
  logic        res_valid = 1'b0;
  logic [15:0] res_pc = '0;
  logic        res_taken = 1'b0;
  logic [1:0]  res_hist = '0;

  logic [15:0] b_fetch_pc = '0;
  logic        b_pred;
  logic [0:0]  b_pred_hist;
  logic        b_res_valid = 1'b0;
  logic [15:0] b_res_pc = '0;
  logic        b_res_taken = 1'b0;
  logic [0:0]  b_res_hist = '0;

  int checks = 0;
  int errors = 0;
  int ref_ctr [32];
  int ref_hist;

  always #4 clk = ~clk;

  corr_bp #(.PC_W(16), .PC_LSB(2), .IDX_W(3), .HIST_W(2), .CTR_W(2)) u_dut (
    .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .pred_taken(pred_taken),
    .pred_hist(pred_hist), .res_valid(res_valid), .res_pc(res_pc),
    .res_taken(res_taken), .res_hist(res_hist));

  corr_bp #(.PC_W(16), .PC_LSB(2), .IDX_W(3), .HIST_W(1), .CTR_W(1)) u_dut_m1n1 (
    .clk(clk), .rst(rst), .fetch_pc(b_fetch_pc), .pred_taken(b_pred),
    .pred_hist(b_pred_hist), .res_valid(b_res_valid), .res_pc(b_res_pc),
    .res_taken(b_res_taken), .res_hist(b_res_hist));

  // {pc[7:0], taken}
  localparam logic [8:0] VEC [20] = '{
    9'h001, 9'h001, 9'h001, 9'h000, 9'h011, 9'h010, 9'h411, 9'h410,
    9'h001, 9'h001, 9'h081, 9'h180, 9'h041, 9'h040, 9'h041, 9'h001,
    9'h000, 9'h000, 9'h181, 9'h081};

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; res_valid = 1'b0; b_res_valid = 1'b0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic res(input logic [15:0] pc, input logic [1:0] h, input logic tk);
    @(negedge clk);
    res_valid = 1'b1; res_pc = pc; res_hist = h; res_taken = tk;
    @(posedge clk); #1 res_valid = 1'b0;
  endtask

  // force history to h via a resolve on row 7, then read the entry of pc
  task automatic probe(input logic [15:0] pc, input logic [1:0] h, input logic exp,
                       input string tag);
    res(16'h001C, {1'b0, h[1]}, h[0]);
    @(negedge clk); fetch_pc = pc; #1;
    check({tag, " hist"}, pred_hist, h);
    check(tag, pred_taken, exp);
  endtask

  task automatic b_step(input logic [15:0] pc, input logic tk, inout int miss);
    @(negedge clk); b_fetch_pc = pc; #1;
    if (b_pred != tk) miss++;
    b_res_valid = 1'b1; b_res_pc = pc; b_res_hist = b_pred_hist; b_res_taken = tk;
    @(posedge clk); #1 b_res_valid = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1: reset state on both instances
    @(negedge clk); #1;
    check("R1 history", pred_hist, 0);
    for (int r = 0; r < 8; r++) begin
      fetch_pc = 16'(r * 4); b_fetch_pc = 16'(r * 4); #1;
      check("R1 pred", pred_taken, 0);
      check("R1 m1n1 pred", b_pred, 0);
    end

    // R2/R7: vector walk against a model built from the requirements
    for (int i = 0; i < 32; i++) ref_ctr[i] = 1;
    ref_hist = 0;
    for (int v = 0; v < 20; v++) begin
      int pc;
      int tk;
      int idx;
      pc  = int'(VEC[v][8:1]);
      tk  = int'(VEC[v][0]);
      idx = ((pc >> 2) & 7) * 4 + ref_hist;
      @(negedge clk); fetch_pc = 16'(pc); #1;
      check("R2 vector pred", pred_taken, ref_ctr[idx] >> 1);
      check("R7 vector hist", pred_hist, ref_hist);
      res_valid = 1'b1; res_pc = 16'(pc); res_hist = pred_hist; res_taken = tk[0];
      @(posedge clk); #1 res_valid = 1'b0;
      if (tk == 1) ref_ctr[idx] = (ref_ctr[idx] == 3) ? 3 : ref_ctr[idx] + 1;
      else         ref_ctr[idx] = (ref_ctr[idx] == 0) ? 0 : ref_ctr[idx] - 1;
      ref_hist = ((ref_hist << 1) | tk) & 3;
    end

    do_reset();
    // R3/R4: hysteresis and saturation on row 0, history 00
    probe(16'h0000, 2'b00, 1'b0, "R2 weak start");
    res(16'h0000, 2'b00, 1'b1);
    probe(16'h0000, 2'b00, 1'b1, "R3 step up from weak");
    res(16'h0000, 2'b00, 1'b1);
    res(16'h0000, 2'b00, 1'b0);
    probe(16'h0000, 2'b00, 1'b1, "R4 one miss holds");
    res(16'h0000, 2'b00, 1'b0);
    probe(16'h0000, 2'b00, 1'b0, "R4 second miss flips");
    for (int k = 0; k < 4; k++) res(16'h0000, 2'b00, 1'b1);
    res(16'h0000, 2'b00, 1'b0);
    probe(16'h0000, 2'b00, 1'b1, "R3 saturate high");
    for (int k = 0; k < 5; k++) res(16'h0000, 2'b00, 1'b0);
    res(16'h0000, 2'b00, 1'b1);
    probe(16'h0000, 2'b00, 1'b0, "R3 saturate low");

    // R5: separate counters per history pattern
    res(16'h0004, 2'b01, 1'b1);
    res(16'h0004, 2'b01, 1'b1);
    probe(16'h0004, 2'b01, 1'b1, "R5 trained pattern");
    probe(16'h0004, 2'b10, 1'b0, "R5 other pattern 10");
    probe(16'h0004, 2'b00, 1'b0, "R5 other pattern 00");

    // R6: 0x28 aliases onto the row of 0x08
    res(16'h0028, 2'b00, 1'b1);
    res(16'h0028, 2'b00, 1'b1);
    probe(16'h0008, 2'b00, 1'b1, "R6 alias shares");

    // R8: update uses returned history, not current history
    probe(16'h000C, 2'b00, 1'b0, "R8 before");
    res(16'h000C, 2'b11, 1'b1);
    res(16'h000C, 2'b11, 1'b1);
    probe(16'h000C, 2'b00, 1'b0, "R8 current history entry untouched");
    probe(16'h000C, 2'b11, 1'b1, "R8 returned history entry trained");

    // R7: history built from returned history plus outcome
    res(16'h0010, 2'b10, 1'b1);
    @(negedge clk); #1 check("R7 shift taken", pred_hist, 2'b01);
    res(16'h0010, 2'b01, 1'b0);
    @(negedge clk); #1 check("R7 shift not-taken", pred_hist, 2'b10);

    // R9: strobe low, other resolve inputs busy for three edges
    @(negedge clk);
    res_valid = 1'b0; res_pc = 16'h000C; res_hist = 2'b11; res_taken = 1'b0;
    @(negedge clk); @(negedge clk); @(negedge clk); #1;
    check("R9 history held", pred_hist, 2'b10);
    probe(16'h000C, 2'b11, 1'b1, "R9 counter held");

    // R10: same entry fetched and resolved in one cycle
    probe(16'h0014, 2'b00, 1'b0, "R10 setup");
    @(negedge clk);
    fetch_pc = 16'h0014;
    res_valid = 1'b1; res_pc = 16'h0014; res_hist = 2'b00; res_taken = 1'b1; #1;
    check("R10 pre-update value", pred_taken, 0);
    @(posedge clk); #1 res_valid = 1'b0;
    probe(16'h0014, 2'b00, 1'b1, "R10 update landed");

    // R11: correlated pair on m=1, n=1
    begin
      int miss_first;
      int miss_rest;
      miss_first = 0; miss_rest = 0;
      b_step(16'h0010, 1'b1, miss_first);
      b_step(16'h0014, 1'b1, miss_first);
      b_step(16'h0010, 1'b0, miss_first);
      b_step(16'h0014, 1'b0, miss_first);
      for (int p = 0; p < 3; p++) begin
        b_step(16'h0010, 1'b1, miss_rest);
        b_step(16'h0014, 1'b1, miss_rest);
        b_step(16'h0010, 1'b0, miss_rest);
        b_step(16'h0014, 1'b0, miss_rest);
      end
      check("R11 first pass misses", miss_first, 2);
      check("R11 later pass misses", miss_rest, 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule